// File: doc/BRIEF.md
# Power-of-Two Frame Allocator

This block hands out and takes back contiguous runs of physical frames from a fixed pool. Every run is a power of two in length and starts at a frame index that is a multiple of its length. An allocate request names the wanted size as an order k, meaning 2^k frames. The block answers with the base frame of a free run of that size, or with a no-space status. A release request names a base frame and an order. It puts that run back into the pool and joins it with its partner run as many times as it can.

Internally the block keeps one free bitmap per order. An allocation takes the smallest order at or above k that still has a free run and picks the lowest-indexed run there. It then halves that run step by step until the size matches, and each upper half it splits off becomes free. A release looks at the partner run at the same order, whose base differs only in the bit of weight 2^j. If the partner is free, the two become one run of the next order, and the check repeats one order higher. The block takes one operation at a time and signals progress with a busy/done handshake.

Top module: `buddy_frame_alloc`

## Requirements
- R1: After reset the whole pool of 2^FRAMES_LOG2 frames (64 by default) is one free run of the top order, and busy and done are low.
- R2: An operation is accepted when op_valid is high and busy is low. Busy stays high while the operation runs. Done is high for the cycle after the operation completes, with busy low in that cycle. resp_status and resp_base hold until the next completion.
- R3: An allocate of order k takes the smallest order j >= k that holds a free run, and within that order the run with the lowest index.
- R4: When the chosen run is larger than 2^k, it is halved repeatedly. At each order between k and j, the upper half becomes a free run.
- R5: A successful allocate returns status 0 (ok) and a resp_base that is a multiple of 2^k, with the whole run inside the pool.
- R6: An allocate returns status 1 (no space), with no change to the pool, when no order from k to the top holds a free run, or when k exceeds the top order.
- R7: A successful release returns status 0. The run is joined with its partner (base XOR 2^j) while that partner is free at the same order j, repeating upward. resp_base is the base of the final joined run.
- R8: A release of a run that overlaps any frame already free returns status 2 (bad release) and leaves the pool unchanged.
- R9: A release with a base that is not a multiple of 2^k, or with an order above the top order, returns status 2 and leaves the pool unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request, taken when busy is low |
| op_free | input | 1 | 1 = release, 0 = allocate |
| op_order | input | ORD_W | Size order k of the run (2^k frames) |
| op_base | input | FRAMES_LOG2 | Base frame of the run to release |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion strobe |
| resp_status | output | 2 | 0 ok, 1 no space, 2 bad release |
| resp_base | output | FRAMES_LOG2 | Allocated base, or base of the joined run after a release |

## Verification
For each order in turn, the pool is emptied by repeated allocation and then refilled. The bases are expected to be the arithmetic sequence i·2^k, and the count that succeeds is expected to be 64>>k. This separates a wrong order choice from wrong splitting, and the last release proves that every join cascades to the top. A short directed mix of orders 0, 1 and 2 checks that split-off upper halves are reused before larger runs are split. A double release, an overlapping release and a misaligned release are each followed by allocations, which show that the pool did not change. A long pseudo-random run of mixed allocates and releases, some of them bogus, is compared against an arithmetic frame-level model.

// File: rtl/buddy_alloc_pkg.sv
package buddy_alloc_pkg;

   typedef enum logic [1:0] {
      BA_OK       = 2'd0,
      BA_NOSPACE  = 2'd1,
      BA_BADFREE  = 2'd2
   } ba_status_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEARCH,
      ST_SPLIT,
      ST_MERGE
   } ba_state_e;

   // start of order j inside the flat bitmap: orders are packed from 0 upward
   function automatic int level_base(input int lg, input int j);
      return (1 << (lg + 1)) - (1 << (lg + 1 - j));
   endfunction

endpackage

// File: rtl/buddy_lowest_set.sv
module buddy_lowest_set #(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3
) (
   input  logic [WIDTH-1:0] vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/buddy_level_view.sv
module buddy_level_view #(
   parameter int LG    = 6,
   parameter int LEVEL = 0,
   parameter int ORD_W = 3,
   localparam int NBLK = 1 << (LG - LEVEL)
) (
   input  logic [NBLK-1:0]  free_bits,
   input  logic [LG-1:0]    req_base,
   input  logic [ORD_W-1:0] req_order,
   output logic             any_free,
   output logic [LG-1:0]    low_idx,
   output logic             overlap
);
   logic [NBLK-1:0] hit;

   always_comb begin
      int rlo;
      int rhi;
      rlo = int'(req_base);
      rhi = rlo + (1 << int'(req_order));
      for (int i = 0; i < NBLK; i++) begin
         hit[i] = ((i << LEVEL) < rhi) && (rlo < ((i + 1) << LEVEL));
      end
   end

   assign overlap = |(free_bits & hit);

   buddy_lowest_set #(.WIDTH(NBLK), .IDX_W(LG)) u_pick (
      .vec   (free_bits),
      .found (any_free),
      .idx   (low_idx)
   );
endmodule

// File: rtl/buddy_frame_alloc.sv
module buddy_frame_alloc #(
   parameter int FRAMES_LOG2 = 6,
   localparam int ORD_W = $clog2(FRAMES_LOG2 + 1),
   localparam int ADDR_W = FRAMES_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic              op_free,
   input  logic [ORD_W-1:0]  op_order,
   input  logic [ADDR_W-1:0] op_base,
   output logic              busy,
   output logic              done,
   output logic [1:0]        resp_status,
   output logic [ADDR_W-1:0] resp_base
);
   import buddy_alloc_pkg::*;

   localparam int MAX_ORD = FRAMES_LOG2;
   localparam int TOTAL   = (1 << (FRAMES_LOG2 + 1)) - 1;
   localparam logic [ORD_W-1:0] MAX_ORD_V = ORD_W'(MAX_ORD);

   initial begin
      assert (FRAMES_LOG2 >= 2 && FRAMES_LOG2 <= 10)
         else $error("FRAMES_LOG2 out of supported range");
   end

   logic [TOTAL-1:0]  free_q;
   ba_state_e         state_q;
   logic [ORD_W-1:0]  cur_ord_q, req_ord_q;
   logic [ADDR_W-1:0] cur_idx_q;
   logic              done_q;
   ba_status_e        status_q;
   logic [ADDR_W-1:0] base_q;

   logic [MAX_ORD:0]  lvl_any, lvl_ovl;
   logic [ADDR_W-1:0] lvl_idx [MAX_ORD+1];

   for (genvar g = 0; g <= MAX_ORD; g++) begin : g_level
      localparam int OFS = level_base(FRAMES_LOG2, g);
      buddy_level_view #(.LG(FRAMES_LOG2), .LEVEL(g), .ORD_W(ORD_W)) u_view (
         .free_bits (free_q[OFS +: (1 << (FRAMES_LOG2 - g))]),
         .req_base  (op_base),
         .req_order (op_order),
         .any_free  (lvl_any[g]),
         .low_idx   (lvl_idx[g]),
         .overlap   (lvl_ovl[g])
      );
   end

   function automatic int pos(input int j, input int idx);
      return level_base(FRAMES_LOG2, j) + idx;
   endfunction

   logic [ADDR_W-1:0] align_mask;
   logic              bad_free;
   logic [ADDR_W-1:0] buddy_idx, split_idx;

   always_comb begin
      align_mask = ADDR_W'((1 << int'(op_order)) - 1);
      bad_free   = (op_order > MAX_ORD_V) || ((op_base & align_mask) != '0) || (|lvl_ovl);
      buddy_idx  = cur_idx_q ^ ADDR_W'(1);
      split_idx  = {cur_idx_q[ADDR_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q            <= '0;
         free_q[TOTAL-1]   <= 1'b1;
         state_q           <= ST_IDLE;
         cur_ord_q         <= '0;
         req_ord_q         <= '0;
         cur_idx_q         <= '0;
         done_q            <= 1'b0;
         status_q          <= BA_OK;
         base_q            <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (op_valid) begin
                  if (op_free) begin
                     if (bad_free) begin
                        done_q   <= 1'b1;
                        status_q <= BA_BADFREE;
                     end else begin
                        state_q   <= ST_MERGE;
                        cur_ord_q <= op_order;
                        cur_idx_q <= op_base >> op_order;
                     end
                  end else if (op_order > MAX_ORD_V) begin
                     done_q   <= 1'b1;
                     status_q <= BA_NOSPACE;
                  end else begin
                     state_q   <= ST_SEARCH;
                     cur_ord_q <= op_order;
                     req_ord_q <= op_order;
                  end
               end
            end
            ST_SEARCH: begin
               if (lvl_any[cur_ord_q]) begin
                  free_q[pos(int'(cur_ord_q), int'(lvl_idx[cur_ord_q]))] <= 1'b0;
                  cur_idx_q <= lvl_idx[cur_ord_q];
                  if (cur_ord_q == req_ord_q) begin
                     state_q  <= ST_IDLE;
                     done_q   <= 1'b1;
                     status_q <= BA_OK;
                     base_q   <= lvl_idx[cur_ord_q] << req_ord_q;
                  end else begin
                     state_q <= ST_SPLIT;
                  end
               end else if (cur_ord_q == MAX_ORD_V) begin
                  state_q  <= ST_IDLE;
                  done_q   <= 1'b1;
                  status_q <= BA_NOSPACE;
               end else begin
                  cur_ord_q <= cur_ord_q + 1'b1;
               end
            end
            ST_SPLIT: begin
               free_q[pos(int'(cur_ord_q) - 1, int'(split_idx) + 1)] <= 1'b1;
               cur_idx_q <= split_idx;
               cur_ord_q <= cur_ord_q - 1'b1;
               if (cur_ord_q - 1'b1 == req_ord_q) begin
                  state_q  <= ST_IDLE;
                  done_q   <= 1'b1;
                  status_q <= BA_OK;
                  base_q   <= split_idx << req_ord_q;
               end
            end
            ST_MERGE: begin
               if (cur_ord_q != MAX_ORD_V && free_q[pos(int'(cur_ord_q), int'(buddy_idx))]) begin
                  free_q[pos(int'(cur_ord_q), int'(buddy_idx))] <= 1'b0;
                  cur_idx_q <= cur_idx_q >> 1;
                  cur_ord_q <= cur_ord_q + 1'b1;
               end else begin
                  free_q[pos(int'(cur_ord_q), int'(cur_idx_q))] <= 1'b1;
                  state_q  <= ST_IDLE;
                  done_q   <= 1'b1;
                  status_q <= BA_OK;
                  base_q   <= cur_idx_q << cur_ord_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign resp_status = status_q;
   assign resp_base   = base_q;

endmodule

// File: rtl/buddy_frame_alloc_chk.sv
module buddy_frame_alloc_chk #(
   parameter int FRAMES_LOG2 = 6,
   localparam int ORD_W = $clog2(FRAMES_LOG2 + 1),
   localparam int ADDR_W = FRAMES_LOG2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              op_free,
   input logic [ORD_W-1:0]  op_order,
   input logic [ADDR_W-1:0] op_base,
   input logic              busy,
   input logic              done,
   input logic [1:0]        resp_status,
   input logic [ADDR_W-1:0] resp_base
);
   logic              lat_free;
   logic [ORD_W-1:0]  lat_order;
   logic [ADDR_W-1:0] lat_base;
   logic [ADDR_W-1:0] lat_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_free  <= 1'b0;
         lat_order <= '0;
         lat_base  <= '0;
      end else if (op_valid && !busy) begin
         lat_free  <= op_free;
         lat_order <= op_order;
         lat_base  <= op_base;
      end
   end

   always_comb lat_mask = ADDR_W'((1 << int'(lat_order)) - 1);

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R2
   AST_FINISH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R2
   AST_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !busy) |=> (busy || done)); // R2
   AST_ALLOC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !lat_free && resp_status == 2'd0) |-> ((resp_base & lat_mask) == '0)); // R5
   AST_OK_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_status == 2'd0) |-> ((int'(resp_base) + (1 << int'(lat_order))) <= (1 << FRAMES_LOG2))); // R5
   AST_NOSPACE_ALLOC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && resp_status == 2'd1) |-> !lat_free); // R6
   AST_MISALIGNED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lat_free && ((lat_base & lat_mask) != '0)) |-> (resp_status == 2'd2)); // R9

endmodule

bind buddy_frame_alloc buddy_frame_alloc_chk #(.FRAMES_LOG2(FRAMES_LOG2)) u_chk (.*);

// File: tb/buddy_frame_alloc_bench.sv
`timescale 1ns/1ps
module buddy_frame_alloc_bench;
   localparam int LG = 6;
   localparam int FR = 1 << LG;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic op_free = 1'b0;
   logic [2:0] op_order = '0;
   logic [LG-1:0] op_base = '0;
   logic busy, done;
   logic [1:0] resp_status;
   logic [LG-1:0] resp_base;

   always #4 clk = ~clk;

   buddy_frame_alloc #(.FRAMES_LOG2(LG)) u_buddy_frame_alloc (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_free(op_free),
      .op_order(op_order), .op_base(op_base), .busy(busy), .done(done),
      .resp_status(resp_status), .resp_base(resp_base)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [FR-1:0] mfree [0:LG];
   logic [FR-1:0] frf;

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int j = 0; j <= LG; j++) mfree[j] = '0;
      mfree[LG][0] = 1'b1;
      frf = '1;
   endtask

   task automatic m_alloc(input int k, output int st, output int b);
      int j, idx;
      bit hit;
      st = 1; b = 0; hit = 0; idx = 0; j = k;
      while (!hit && j <= LG) begin
         for (int i = 0; i < (FR >> j); i++)
            if (!hit && mfree[j][i]) begin hit = 1; idx = i; end
         if (!hit) j++;
      end
      if (hit) begin
         mfree[j][idx] = 1'b0;
         while (j > k) begin
            j--;
            mfree[j][2*idx+1] = 1'b1;
            idx = 2 * idx;
         end
         b = idx << k;
         st = 0;
         for (int f = b; f < b + (1 << k); f++) frf[f] = 1'b0;
      end
   endtask

   task automatic m_free(input int k, input int b, output int st, output int mb);
      int j, idx;
      bit ovl;
      st = 2; mb = 0; ovl = 0;
      if (k > LG) return;
      if ((b % (1 << k)) != 0) return;
      for (int f = b; f < b + (1 << k); f++) if (frf[f]) ovl = 1;
      if (ovl) return;
      for (int f = b; f < b + (1 << k); f++) frf[f] = 1'b1;
      idx = b >> k; j = k;
      while (j < LG && mfree[j][idx ^ 1]) begin
         mfree[j][idx ^ 1] = 1'b0;
         idx = idx >> 1;
         j++;
      end
      mfree[j][idx] = 1'b1;
      mb = idx << j;
      st = 0;
   endtask

   // drive one operation, wait for done, compare with the model
   task automatic do_op(input string tag, input bit is_free, input int k, input int b,
                        output int st, output int rb);
      int est, eb;
      if (is_free) m_free(k, b, est, eb); else m_alloc(k, est, eb);
      @(negedge clk);
      op_valid = 1'b1; op_free = is_free; op_order = 3'(k); op_base = LG'(b);
      @(negedge clk);
      op_valid = 1'b0;
      while (!done) @(negedge clk);
      st = int'(resp_status);
      rb = int'(resp_base);
      check({tag, " status"}, st, est);
      if (est != 1 && est != 2) check({tag, " base"}, rb, eb);
   endtask

   function automatic int unsigned xs(input int unsigned s);
      int unsigned v;
      v = s ^ (s << 13);
      v = v ^ (v >> 17);
      return v ^ (v << 5);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int st, rb, cnt;
      int lb [0:FR-1];
      int lo [0:FR-1];
      int n;
      int unsigned rs;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 done after reset", int'(done), 0);
      do_op("R1 whole pool", 0, 6, 0, st, rb);
      do_op("R6 pool empty", 0, 0, 0, st, rb);
      do_op("R7 release whole", 1, 6, 0, st, rb);
      do_op("R6 order too big", 0, 7, 0, st, rb);

      // R2: busy seen while a deep split runs
      @(negedge clk);
      op_valid = 1'b1; op_free = 1'b0; op_order = 3'd0;
      @(negedge clk);
      op_valid = 1'b0;
      check("R2 busy during op", int'(busy), 1);
      check("R2 done during op", int'(done), 0);
      while (!done) @(negedge clk);
      check("R2 busy at done", int'(busy), 0);
      check("R4 first frame", int'(resp_base), 0);
      begin int d1, d2; m_alloc(0, d1, d2); end
      // R3/R4: split-off halves reused before larger runs
      do_op("R4 order1 next", 0, 1, 0, st, rb);
      check("R4 order1 base", rb, 2);
      do_op("R3 order0 lowest", 0, 0, 0, st, rb);
      check("R3 order0 base", rb, 1);
      do_op("R4 order2", 0, 2, 0, st, rb);
      check("R4 order2 base", rb, 4);
      do_op("R7 free no buddy", 1, 0, 1, st, rb);
      check("R7 unjoined base", rb, 1);
      do_op("R7 join order0", 1, 0, 0, st, rb);
      do_op("R7 join order1", 1, 1, 2, st, rb);
      do_op("R7 join to top", 1, 2, 4, st, rb);
      check("R7 top base", rb, 0);

      // sweep every order: drain, then refill
      for (int k = 0; k <= LG; k++) begin
         cnt = 0;
         for (int i = 0; i < (FR >> k); i++) begin
            do_op("R5 sweep alloc", 0, k, 0, st, rb);
            check("R5 sweep base", rb, i << k);
            if (st == 0) cnt++;
         end
         check("R5 sweep count", cnt, FR >> k);
         do_op("R6 sweep full", 0, k, 0, st, rb);
         check("R6 sweep status", st, 1);
         for (int i = 0; i < (FR >> k); i++) do_op("R7 sweep free", 1, k, i << k, st, rb);
         check("R7 sweep final join", rb, 0);
      end

      // bad releases leave the pool unchanged
      do_op("R8 setup a", 0, 5, 0, st, rb);
      do_op("R8 setup b", 0, 5, 0, st, rb);
      do_op("R8 first free", 1, 5, 0, st, rb);
      do_op("R8 double free", 1, 5, 0, st, rb);
      check("R8 status", st, 2);
      do_op("R8 overlap free", 1, 2, 8, st, rb);
      check("R8 overlap status", st, 2);
      do_op("R8 realloc", 0, 5, 0, st, rb);
      check("R8 realloc base", rb, 0);
      do_op("R8 nothing extra", 0, 0, 0, st, rb);
      check("R8 nothing extra status", st, 1);
      do_op("R9 misaligned", 1, 5, 16, st, rb);
      check("R9 misaligned status", st, 2);
      do_op("R9 big order", 1, 7, 0, st, rb);
      check("R9 big order status", st, 2);
      do_op("R9 still full", 0, 0, 0, st, rb);
      check("R9 still full status", st, 1);
      do_op("R7 cleanup a", 1, 5, 0, st, rb);
      do_op("R7 cleanup b", 1, 5, 32, st, rb);
      check("R7 cleanup join", rb, 0);

      // pseudo-random mix
      n = 0;
      rs = 32'h1234_5678;
      for (int t = 0; t < 800; t++) begin
         rs = xs(rs);
         if (rs[3:2] == 2'b00) begin
            do_op("R8 random bogus free", 1, int'(rs[10:8]) % 8, int'(rs[21:16]), st, rb);
         end else if (n > 0 && rs[1]) begin
            int p;
            p = int'(rs[30:20]) % n;
            do_op("R7 random free", 1, lo[p], lb[p], st, rb);
            lb[p] = lb[n-1]; lo[p] = lo[n-1]; n--;
         end else begin
            int k;
            k = int'(rs[14:12]) % 4;
            do_op("R3 random alloc", 0, k, 0, st, rb);
            if (st == 0 && n < FR) begin lb[n] = rb; lo[n] = k; n++; end
         end
      end

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule